// File: doc/BRIEF.md
# Timestamped Stream Pacing Unit

This block paces fixed-size transport stream source packets against a local bus time base. It keeps a free-running 32-bit cycle timer made of a seconds field, a cycle count and a cycle offset. The offset advances on each pulse of a tick enable. There are two stream ports, and they work independently. Each port has a byte-wide input and a byte-wide output, both with valid/ready handshakes, and a 2 KB packet store that serves either direction.

A port in transmit direction takes 188-byte source packets. It tags each packet with a 4-byte time header and emits the 192-byte stamped frame. The tag is the time at which the packet's first byte arrived, with the cycle field pushed forward by a programmable delay. A port in receive direction takes 192-byte stamped frames. It holds each one until the low 25 timer bits equal the frame's stamp exactly, and then streams out the 188 payload bytes. The direction bit is set per port.

Top module: `ts_pacer`

## Requirements
- R1: Reset clears the cycle timer to zero. On each clock with `tick` high the offset (bits 11:0) advances by one, and from 3071 it returns to 0 and carries into the cycle count (bits 24:12). On a clock with `tick` low the timer holds.
- R2: When a carry reaches a cycle count of 7999, the count returns to 0 and seconds (bits 31:25) advance by one. Seconds roll over from 127 to 0.
- R3: A transmit port emits 192-byte frames. Each frame starts with a 4-byte header sent most significant byte first: bits 31:25 are zero, bits 24:12 are (arrival cycle + `tx_delay`) mod 8000, and bits 11:0 are the arrival offset. The 188 payload bytes follow in input order. The arrival time is the timer value on the clock at which the packet's first byte is accepted.
- R4: A receive port accepts 192-byte frames, which are a 4-byte stamp sent most significant byte first followed by 188 payload bytes. It outputs only the 188 payload bytes, in order.
- R5: In receive direction, `out_valid` rises on the clock after the first clock on which the low 25 timer bits equal stamp bits 24:0 of the oldest stored frame. Stamp bits 31:25 are ignored.
- R6: Packets leave a port in the order they arrived. A younger receive frame whose stamp time comes while an older frame is still held waits for its own next exact match. Once a frame is released it streams out without further timer gating.
- R7: Each port holds 10 packets, which is 2048 bytes divided by 192. While 10 complete packets are stored, `in_ready` is low and offered bytes are not taken. Emptying one slot raises `in_ready` again.
- R8: The two ports are independent. A full or stalled port does not affect the other port's handshakes.
- R9: A change of a port's `mode` bit empties that port. On the clock of the change `in_ready` and `out_valid` are low, and every packet stored before the change is discarded.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_data` hold their values, unless the mode changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timer advance enable (24.576 MHz rate) |
| tx_delay | input | 13 | Cycles added to the arrival cycle for transmit stamps, below 8000 |
| mode | input | 2 | Per-port direction: 1 transmit, 0 receive |
| in_valid | input | 2 | Per-port input byte valid |
| in_data | input | 2x8 | Per-port input byte |
| in_ready | output | 2 | Per-port input ready |
| out_valid | output | 2 | Per-port output byte valid |
| out_data | output | 2x8 | Per-port output byte |
| out_ready | input | 2 | Per-port output ready |
| cycle_time | output | 32 | Current cycle timer value |

## Verification
The bench builds the block with short offset and cycle limits so that every timer carry and the seconds rollover happen in a short run. A timer that carried one step too early or too late would drift away from the bench model at the first wrap. Receive frames are stamped a fixed number of ticks ahead, and the bench checks that release comes exactly one clock after the matching time. A comparator that used `>=`, or that registered the comparison one stage late, would release a cycle off. One test sends a younger frame with an earlier stamp, and that frame must wait a full timer period. Random stalls on the output check that held data stays stable. Other tests fill a port to ten packets and flip a port's mode with data inside. A design that took the eleventh packet, or kept stale frames across a mode change, would fail these tests.

// File: rtl/ts_pace_pkg.sv
package ts_pace_pkg;

    localparam int HDR_BYTES = 4;
    localparam int TAG_W     = 25;

    typedef struct packed {
        logic [6:0]  sec;
        logic [12:0] cyc;
        logic [11:0] ofs;
    } ctime_t;

    typedef enum logic {
        DIR_RX = 1'b0,
        DIR_TX = 1'b1
    } dir_e;

    // Cycle field plus a delay, reduced modulo the cycle limit.
    function automatic logic [12:0] cyc_add(input logic [12:0] a,
                                            input logic [12:0] d,
                                            input int unsigned lim);
        logic [13:0] s;
        s = {1'b0, a} + {1'b0, d};
        if (s >= 14'(lim))
            s = s - 14'(lim);
        return s[12:0];
    endfunction

endpackage

// File: rtl/cycle_timer.sv
module cycle_timer
    import ts_pace_pkg::*;
#(
    parameter int OFS_LIMIT = 3072,
    parameter int CYC_LIMIT = 8000
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   tick,
    output ctime_t now
);

    localparam logic [11:0] OFS_LAST = 12'(OFS_LIMIT - 1);
    localparam logic [12:0] CYC_LAST = 13'(CYC_LIMIT - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            now <= '0;
        end else if (tick) begin
            if (now.ofs == OFS_LAST) begin
                now.ofs <= '0;
                if (now.cyc == CYC_LAST) begin
                    now.cyc <= '0;
                    now.sec <= now.sec + 7'd1;
                end else begin
                    now.cyc <= now.cyc + 13'd1;
                end
            end else begin
                now.ofs <= now.ofs + 12'd1;
            end
        end
    end

endmodule

// File: rtl/pace_store.sv
module pace_store #(
    parameter int DEPTH = 1880,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/pace_port.sv
module pace_port
    import ts_pace_pkg::*;
#(
    parameter int PKT_BYTES = 188,
    parameter int NSLOT     = 10
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             dir_tx,
    input  logic [TAG_W-1:0] now_tag,
    input  logic [31:0]      tx_tag,
    input  logic             in_valid,
    input  logic [7:0]       in_data,
    output logic             in_ready,
    output logic             out_valid,
    output logic [7:0]       out_data,
    input  logic             out_ready
);

    localparam int FRAME = PKT_BYTES + HDR_BYTES;
    localparam int DEPTH = PKT_BYTES * NSLOT;
    localparam int SW    = $clog2(NSLOT);
    localparam int IW    = $clog2(FRAME);
    localparam int AW    = $clog2(DEPTH);
    localparam int CW    = $clog2(NSLOT + 1);

    localparam logic [IW-1:0] PKT_LAST   = IW'(PKT_BYTES - 1);
    localparam logic [IW-1:0] FRAME_LAST = IW'(FRAME - 1);
    localparam logic [IW-1:0] HDR_N      = IW'(HDR_BYTES);
    localparam logic [SW-1:0] SLOT_LAST  = SW'(NSLOT - 1);
    localparam logic [CW-1:0] FULL_N     = CW'(NSLOT);

    dir_e          dir_q;
    logic          flush, is_tx;
    logic [SW-1:0] wr_slot, rd_slot;
    logic [IW-1:0] wr_idx, rd_idx, wr_off, rd_off;
    logic [CW-1:0] count;
    logic          released;
    logic [31:0]   tag_mem [NSLOT];
    logic [31:0]   head_tag;
    logic          in_hdr, out_hdr;
    logic          wr_fire, rd_fire, wr_last, rd_last, match;
    logic [AW-1:0] waddr, raddr;
    logic [7:0]    rdata, hdr_byte;

    assign flush   = (dir_e'(dir_tx) != dir_q);
    assign is_tx   = (dir_q == DIR_TX);

    assign in_ready = !flush && (count < FULL_N);
    assign wr_fire  = in_valid && in_ready;
    assign in_hdr   = !is_tx && (wr_idx < HDR_N);
    assign wr_last  = wr_fire && (wr_idx == (is_tx ? PKT_LAST : FRAME_LAST));

    assign head_tag = tag_mem[rd_slot];
    assign match    = !is_tx && (count != '0) && !released &&
                      (head_tag[TAG_W-1:0] == now_tag);

    assign out_valid = !flush && (count != '0) && (is_tx || released);
    assign out_hdr   = is_tx && (rd_idx < HDR_N);
    assign rd_fire   = out_valid && out_ready;
    assign rd_last   = rd_fire && (rd_idx == (is_tx ? FRAME_LAST : PKT_LAST));

    assign wr_off = is_tx ? wr_idx : (wr_idx - HDR_N);
    assign rd_off = out_hdr ? '0 : (is_tx ? (rd_idx - HDR_N) : rd_idx);
    assign waddr  = AW'(wr_slot) * AW'(PKT_BYTES) + AW'(wr_off);
    assign raddr  = AW'(rd_slot) * AW'(PKT_BYTES) + AW'(rd_off);

    always_comb begin
        case (rd_idx[1:0])
            2'd0:    hdr_byte = head_tag[31:24];
            2'd1:    hdr_byte = head_tag[23:16];
            2'd2:    hdr_byte = head_tag[15:8];
            default: hdr_byte = head_tag[7:0];
        endcase
    end

    assign out_data = out_hdr ? hdr_byte : rdata;

    pace_store #(
        .DEPTH (DEPTH),
        .AW    (AW)
    ) u_store (
        .clk   (clk),
        .we    (wr_fire && !in_hdr),
        .waddr (waddr),
        .wdata (in_data),
        .raddr (raddr),
        .rdata (rdata)
    );

    always_ff @(posedge clk) begin
        if (wr_fire) begin
            if (is_tx && wr_idx == '0)
                tag_mem[wr_slot] <= tx_tag;
            else if (in_hdr)
                tag_mem[wr_slot] <= {tag_mem[wr_slot][23:0], in_data};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            dir_q    <= dir_e'(dir_tx);
            wr_slot  <= '0;
            wr_idx   <= '0;
            rd_slot  <= '0;
            rd_idx   <= '0;
            count    <= '0;
            released <= 1'b0;
        end else begin
            if (wr_fire) begin
                wr_idx <= wr_last ? '0 : wr_idx + 1'b1;
                if (wr_last)
                    wr_slot <= (wr_slot == SLOT_LAST) ? '0 : wr_slot + 1'b1;
            end
            if (rd_fire) begin
                rd_idx <= rd_last ? '0 : rd_idx + 1'b1;
                if (rd_last)
                    rd_slot <= (rd_slot == SLOT_LAST) ? '0 : rd_slot + 1'b1;
            end
            if (rd_last)
                released <= 1'b0;
            else if (match)
                released <= 1'b1;
            count <= count + CW'(wr_last) - CW'(rd_last);
        end
    end

endmodule

// File: rtl/ts_pacer.sv
module ts_pacer
    import ts_pace_pkg::*;
#(
    parameter int NPORT     = 2,
    parameter int PKT_BYTES = 188,
    parameter int BUF_BYTES = 2048,
    parameter int OFS_LIMIT = 3072,
    parameter int CYC_LIMIT = 8000
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  tick,
    input  logic [12:0]           tx_delay,
    input  logic [NPORT-1:0]      mode,
    input  logic [NPORT-1:0]      in_valid,
    input  logic [NPORT-1:0][7:0] in_data,
    output logic [NPORT-1:0]      in_ready,
    output logic [NPORT-1:0]      out_valid,
    output logic [NPORT-1:0][7:0] out_data,
    input  logic [NPORT-1:0]      out_ready,
    output logic [31:0]           cycle_time
);

    localparam int NSLOT = BUF_BYTES / (PKT_BYTES + HDR_BYTES);

    ctime_t      now;
    logic [31:0] tx_tag;

    cycle_timer #(
        .OFS_LIMIT (OFS_LIMIT),
        .CYC_LIMIT (CYC_LIMIT)
    ) u_timer (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .now  (now)
    );

    assign cycle_time = now;
    assign tx_tag     = {7'd0, cyc_add(now.cyc, tx_delay, CYC_LIMIT), now.ofs};

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        pace_port #(
            .PKT_BYTES (PKT_BYTES),
            .NSLOT     (NSLOT)
        ) u_port (
            .clk       (clk),
            .rst       (rst),
            .dir_tx    (mode[p]),
            .now_tag   (now[TAG_W-1:0]),
            .tx_tag    (tx_tag),
            .in_valid  (in_valid[p]),
            .in_data   (in_data[p]),
            .in_ready  (in_ready[p]),
            .out_valid (out_valid[p]),
            .out_data  (out_data[p]),
            .out_ready (out_ready[p])
        );
    end

endmodule

// File: rtl/ts_pacer_chk.sv
module ts_pacer_chk #(
    parameter int NPORT     = 2,
    parameter int OFS_LIMIT = 3072,
    parameter int CYC_LIMIT = 8000
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  tick,
    input logic [NPORT-1:0]      mode,
    input logic [NPORT-1:0]      in_ready,
    input logic [NPORT-1:0]      out_valid,
    input logic [NPORT-1:0][7:0] out_data,
    input logic [NPORT-1:0]      out_ready,
    input logic [31:0]           cycle_time
);

    localparam logic [11:0] OFS_LAST = 12'(OFS_LIMIT - 1);
    localparam logic [12:0] CYC_LAST = 13'(CYC_LIMIT - 1);

    a_r1_ofs_range: assert property (@(posedge clk) disable iff (rst)
        cycle_time[11:0] <= OFS_LAST);

    a_r2_cyc_range: assert property (@(posedge clk) disable iff (rst)
        cycle_time[24:12] <= CYC_LAST);

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(cycle_time));

    a_r1_step: assert property (@(posedge clk) disable iff (rst)
        (tick && cycle_time[11:0] != OFS_LAST) |=>
        (cycle_time[11:0] == $past(cycle_time[11:0]) + 12'd1) &&
        (cycle_time[31:12] == $past(cycle_time[31:12])));

    a_r2_carry: assert property (@(posedge clk) disable iff (rst)
        (tick && cycle_time[11:0] == OFS_LAST && cycle_time[24:12] != CYC_LAST) |=>
        (cycle_time[11:0] == 12'd0) &&
        (cycle_time[24:12] == $past(cycle_time[24:12]) + 13'd1));

    for (genvar p = 0; p < NPORT; p++) begin : g_chk
        a_r10_hold: assert property (@(posedge clk) disable iff (rst)
            (out_valid[p] && !out_ready[p]) |=>
            ((out_valid[p] && $stable(out_data[p])) || (mode[p] != $past(mode[p]))));

        a_r9_flush: assert property (@(posedge clk) disable iff (rst)
            (mode[p] != $past(mode[p])) |-> (!out_valid[p] && !in_ready[p]));
    end

endmodule

bind ts_pacer ts_pacer_chk #(
    .NPORT     (NPORT),
    .OFS_LIMIT (OFS_LIMIT),
    .CYC_LIMIT (CYC_LIMIT)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .mode       (mode),
    .in_ready   (in_ready),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_ready  (out_ready),
    .cycle_time (cycle_time)
);

// File: tb/sim_ts_pacer.sv
module sim_ts_pacer;

    localparam int NP    = 2;
    localparam int PKT   = 188;
    localparam int FRM   = 192;
    localparam int OFS_L = 16;
    localparam int CYC_L = 10;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic [12:0]      tx_delay = '0;
    logic [NP-1:0]    mode = '1;
    logic [NP-1:0]    in_valid = '0;
    logic [NP-1:0][7:0] in_data = '0;
    logic [NP-1:0]    in_ready;
    logic [NP-1:0]    out_valid;
    logic [NP-1:0][7:0] out_data;
    logic [NP-1:0]    out_ready = '0;
    logic [31:0]      cycle_time;

    int checks = 0;
    int errors = 0;

    logic [7:0]  sbuf [NP][2][FRM];
    logic [7:0]  got  [NP][FRM];
    logic [7:0]  first_pkt [PKT];
    logic [31:0] arr_t [NP];
    logic [31:0] exp_t;
    logic        mon_en = 1'b0;
    logic        sec_wrapped = 1'b0;
    logic [31:0] last_seen = '0;

    always #2 clk = ~clk;

    ts_pacer #(
        .NPORT     (NP),
        .PKT_BYTES (PKT),
        .BUF_BYTES (2048),
        .OFS_LIMIT (OFS_L),
        .CYC_LIMIT (CYC_L)
    ) u0 (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .tx_delay   (tx_delay),
        .mode       (mode),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_ready  (out_ready),
        .cycle_time (cycle_time)
    );

    function automatic logic [31:0] next_t(input logic [31:0] t);
        logic [6:0]  s;
        logic [12:0] c;
        logic [11:0] o;
        s = t[31:25]; c = t[24:12]; o = t[11:0];
        if (o == 12'(OFS_L - 1)) begin
            o = 0;
            if (c == 13'(CYC_L - 1)) begin c = 0; s = s + 1; end
            else c = c + 1;
        end else o = o + 1;
        return {s, c, o};
    endfunction

    function automatic logic [31:0] add_ticks(input logic [31:0] t, input int k);
        logic [31:0] r;
        r = t;
        for (int i = 0; i < k; i++) r = next_t(r);
        return r;
    endfunction

    function automatic logic [31:0] mk_tag(input logic [31:0] t, input int d);
        int c;
        c = (int'(t[24:12]) + d) % CYC_L;
        return {7'd0, 13'(c), t[11:0]};
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, expv);
        end
    endtask

    // timer model (R1, R2)
    always @(posedge clk) begin
        if (rst) exp_t <= '0;
        else if (tick) exp_t <= next_t(exp_t);
    end

    always @(negedge clk) begin
        if (!rst && mon_en) begin
            chk(cycle_time == exp_t, "R1/R2 timer", cycle_time, exp_t);
            if (last_seen[31:25] == 7'd127 && cycle_time[31:25] == 7'd0)
                sec_wrapped = 1'b1;
            last_seen = cycle_time;
        end
    end

    task automatic send(input int p, input int s, input int len);
        for (int i = 0; i < len; i++) begin
            in_valid[p] = 1'b1;
            in_data[p]  = sbuf[p][s][i];
            while (!in_ready[p]) @(negedge clk);
            if (i == 0) arr_t[p] = cycle_time;
            @(negedge clk);
        end
        in_valid[p] = 1'b0;
    endtask

    task automatic recv(input int p, input int n, input bit rnd);
        int idx;
        bit stalled;
        logic [7:0] held;
        idx = 0; stalled = 0; held = '0;
        while (idx < n) begin
            @(negedge clk);
            if (stalled)
                chk(out_valid[p] && out_data[p] == held, "R10 held output",
                    {23'd0, out_valid[p], out_data[p]}, {24'd1, held});
            out_ready[p] = rnd ? 1'($urandom % 2) : 1'b1;
            if (out_valid[p]) begin
                if (out_ready[p]) begin
                    got[p][idx] = out_data[p];
                    idx++;
                    stalled = 0;
                end else begin
                    stalled = 1;
                    held = out_data[p];
                end
            end else stalled = 0;
        end
        @(negedge clk);
        out_ready[p] = 1'b0;
    endtask

    // waits with out_ready low; checks release follows the exact match
    task automatic wait_release(input int p, input logic [31:0] tag, input string req);
        logic [31:0] prev;
        int n;
        prev = cycle_time; n = 0;
        while (n < 400) begin
            @(negedge clk);
            if (out_valid[p]) break;
            prev = cycle_time;
            n++;
        end
        chk(out_valid[p] && prev[24:0] == tag[24:0], req, prev, tag);
    endtask

    task automatic fill_payload(input int p, input int s, input int base);
        for (int i = 0; i < PKT; i++) sbuf[p][s][base + i] = 8'($urandom);
    endtask

    task automatic fill_rx(input int p, input int s, input logic [31:0] tag);
        sbuf[p][s][0] = tag[31:24]; sbuf[p][s][1] = tag[23:16];
        sbuf[p][s][2] = tag[15:8];  sbuf[p][s][3] = tag[7:0];
        fill_payload(p, s, 4);
    endtask

    task automatic cmp_payload(input int p, input int s, input int goff,
                               input int soff, input string req);
        int bad;
        bad = -1;
        for (int i = 0; i < PKT; i++)
            if (bad < 0 && got[p][goff + i] != sbuf[p][s][soff + i]) bad = i;
        if (bad < 0) chk(1'b1, req, 0, 0);
        else chk(1'b0, req, {24'd0, got[p][goff + bad]}, {24'd0, sbuf[p][s][soff + bad]});
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] tg, t1, t2;
        int d;
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // reset state
        chk(cycle_time == 32'd0, "R1 reset timer", cycle_time, 0);
        chk(out_valid == '0, "R1 reset out_valid", {30'd0, out_valid}, 0);
        chk(in_ready == 2'b11, "R7 reset in_ready", {30'd0, in_ready}, 3);
        mon_en = 1'b1;

        // R1: random tick pattern
        for (int i = 0; i < 300; i++) begin
            tick = 1'($urandom % 2);
            @(negedge clk);
        end
        // R2: run past the seconds rollover
        tick = 1'b1;
        repeat (128 * OFS_L * CYC_L + 40) @(negedge clk);
        chk(sec_wrapped, "R2 seconds rollover", {31'd0, sec_wrapped}, 1);

        // R3: transmit stamping, several delays including the cycle wrap
        for (int k = 0; k < 4; k++) begin
            d = (k == 0) ? CYC_L - 1 : int'($urandom % CYC_L);
            tx_delay = 13'(d);
            fill_payload(0, 0, 0);
            fork
                send(0, 0, PKT);
                recv(0, FRM, 1'b1);
            join
            tg = mk_tag(arr_t[0], d);
            chk({got[0][0], got[0][1], got[0][2], got[0][3]} == tg, "R3 header",
                {got[0][0], got[0][1], got[0][2], got[0][3]}, tg);
            cmp_payload(0, 0, 4, 0, "R3 payload");
        end

        // R4/R5: receive on port 1
        mode[1] = 1'b0;
        repeat (2) @(negedge clk);
        for (int k = 0; k < 3; k++) begin
            tg = {7'($urandom), 13'($urandom % CYC_L), 12'($urandom % OFS_L)};
            if (k == 0) tg[31:25] = 7'd0;
            fill_rx(1, 0, tg);
            send(1, 0, FRM);
            wait_release(1, tg, "R5 release on exact match");
            recv(1, PKT, 1'b1);
            cmp_payload(1, 0, 0, 4, "R4 payload only");
        end

        // R6: younger frame stamped earlier must wait for its own match
        t1 = {7'd0, 13'($urandom % CYC_L), 12'($urandom % OFS_L)};
        t2 = add_ticks(t1, OFS_L * CYC_L - 5);
        fill_rx(1, 0, t1);
        fill_rx(1, 1, t2);
        send(1, 0, FRM);
        fork
            send(1, 1, FRM);
            begin
                wait_release(1, t1, "R6 older first");
                recv(1, PKT, 1'b0);
            end
        join
        cmp_payload(1, 0, 0, 4, "R6 order first");
        wait_release(1, t2, "R6 younger waits");
        recv(1, PKT, 1'b0);
        cmp_payload(1, 1, 0, 4, "R6 order second");

        // R7/R8: fill port 0 to capacity
        tx_delay = 13'd3;
        for (int k = 0; k < 10; k++) begin
            fill_payload(0, 0, 0);
            if (k == 0) begin
                for (int i = 0; i < PKT; i++) first_pkt[i] = sbuf[0][0][i];
            end
            send(0, 0, PKT);
            if (k == 0) t1 = arr_t[0];
        end
        chk(in_ready[0] == 1'b0, "R7 full stalls input", {31'd0, in_ready[0]}, 0);
        chk(in_ready[1] == 1'b1 && out_valid[1] == 1'b0, "R8 other port free",
            {30'd0, in_ready[1], out_valid[1]}, 2);
        in_valid[0] = 1'b1; in_data[0] = 8'hA5;
        repeat (5) @(negedge clk);
        chk(in_ready[0] == 1'b0, "R7 full holds off", {31'd0, in_ready[0]}, 0);
        in_valid[0] = 1'b0;
        recv(0, FRM, 1'b1);
        for (int i = 0; i < PKT; i++) sbuf[0][1][i] = first_pkt[i];
        tg = mk_tag(t1, 3);
        chk({got[0][0], got[0][1], got[0][2], got[0][3]} == tg, "R7 oldest header",
            {got[0][0], got[0][1], got[0][2], got[0][3]}, tg);
        cmp_payload(0, 1, 4, 0, "R7 oldest payload");
        chk(in_ready[0] == 1'b1, "R7 slot freed", {31'd0, in_ready[0]}, 1);

        // R9: mode flip empties the port
        mode[0] = 1'b0;
        #0;
        @(negedge clk);
        chk(out_valid[0] == 1'b0 && in_ready[0] == 1'b1, "R9 rx after flip",
            {30'd0, out_valid[0], in_ready[0]}, 1);
        mode[0] = 1'b1;
        @(negedge clk);
        repeat (3) @(negedge clk);
        chk(out_valid[0] == 1'b0, "R9 stored packets discarded", {31'd0, out_valid[0]}, 0);
        chk(in_ready[0] == 1'b1, "R9 input reopens", {31'd0, in_ready[0]}, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule